// File: doc/BRIEF.md
# Multi-Mode Operand Address Unit

This unit takes a memory-operand descriptor that decode has already split into fields, works out where the operand lives, and delivers the operand value. The descriptor has five fields:

- a mode code;
- a base register value and an index register value;
- an immediate that serves as a constant, a displacement or an absolute address, depending on the mode;
- a scale exponent that gives the access size (1, 2, 4 or 8 bytes).

Register and constant operands come back one cycle after `start`. Modes that point into memory issue one read on a single-outstanding request/response port and finish when the response arrives. Memory-indirect mode first reads a pointer and then reads the operand at that pointer. The two post-modify modes also return the updated base register value on a one-cycle write-back strobe.

A request is taken only while the unit is idle. The unit is idle again in the cycle that `done` is high, so the next descriptor can be presented in that same cycle. Memory is assumed to answer each request no earlier than the cycle after the request strobe.

Top module: `ea_unit`

## Requirements
- R1: While reset is low, and in the first cycle after reset is sampled low, `done`, `mem_req` and `wb_en` are 0.
- R2: Mode 0, and the unused codes 10 to 15, select register direct. `done` rises in the cycle after `start` is sampled, with `operand` equal to the base value and `addr` equal to 0. No read is issued.
- R3: Mode 1 (immediate) returns `operand` equal to the immediate with `addr` equal to 0. It has the same timing as R2 and issues no read.
- R4: The read address is formed as follows:
  - mode 2: the base value;
  - mode 3: base plus immediate;
  - mode 4: base plus index;
  - mode 5: the immediate alone.
  All additions wrap at the data width.
- R5: Mode 9 (scaled) reads at immediate plus base plus (index shifted left by the scale exponent).
- R6: For single-read modes, `mem_req` is high for one cycle: the cycle after `start` is sampled. In the cycle after `mem_rvalid`, `done` is high, `operand` holds the returned data and `addr` holds the read address.
- R7: Mode 6 (memory indirect) first reads at the base value. In the cycle after that response, it issues a second read at the returned pointer. `done` follows only the second response, with `addr` equal to the pointer.
- R8: Modes 7 (post-increment) and 8 (post-decrement) read at the unmodified base. In the `done` cycle, `wb_en` is high for one cycle with `wb_data` equal to the base plus or minus (1 shifted left by the scale exponent). `wb_en` is never high for any other mode.
- R9: While a request is in progress, `start` has no effect on the outputs or on the addresses of later reads.
- R10: At most one read is outstanding, and `mem_req` is never high in two consecutive cycles. A new `start` presented in a `done` cycle is accepted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Descriptor valid; taken only when idle |
| mode | input | 4 | Addressing mode code |
| reg_a | input | AW | Base register value |
| reg_b | input | AW | Index register value |
| imm | input | AW | Immediate, displacement or absolute address |
| size_log2 | input | SZW | Scale exponent (access size = 1 << size_log2) |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | AW | Read response data |
| mem_req | output | 1 | One-cycle read request strobe |
| mem_addr | output | AW | Read address, valid with `mem_req` |
| done | output | 1 | Operand ready |
| operand | output | AW | Operand value, valid with `done` |
| addr | output | AW | Final effective address, valid with `done` |
| wb_en | output | 1 | Base write-back strobe |
| wb_data | output | AW | Updated base value, valid with `wb_en` |

## Verification
There are two kinds of collision to provoke:

- **End of one request and start of the next.** The completion of one request, including a post-modify write-back, can fall in the same cycle that the next descriptor is accepted. The bench therefore presents each new descriptor in the very cycle `done` is observed, chaining register, post-modify and memory-indirect requests back to back.
- **Busy and new `start`.** A new `start` can also arrive while a read is still pending. The bench holds `start` high with a different mode during a long memory latency.

A behavioural model that tracks the pending read count decides, in every cycle, which strobes and values are due. Any extra `done`, request or write-back, or a wrong address, is reported against the requirement under test.

// File: rtl/ea_pkg.sv
// Package: shared mode codes and the classification record passed from the
// address generator to the sequencer.
package ea_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        EM_REG     = 4'd0,
        EM_IMM     = 4'd1,
        EM_RIND    = 4'd2,
        EM_DISP    = 4'd3,
        EM_IDX     = 4'd4,
        EM_ABS     = 4'd5,
        EM_MIND    = 4'd6,
        EM_POSTINC = 4'd7,
        EM_POSTDEC = 4'd8,
        EM_SCALED  = 4'd9
    } ea_mode_e;

    typedef struct packed {
        logic needs_mem;    // at least one memory read
        logic two_level;    // pointer read precedes operand read
        logic writes_base;  // base register write-back at completion
    } ea_class_t;

endpackage

// File: rtl/ea_addr_gen.sv
// Module: ea_addr_gen
// Purpose: purely combinational decode of one operand descriptor.
// Produces the effective address, the value returned for non-memory modes,
// the post-modify base value, and the mode class.
// Assumes: the inputs are stable in the cycle start is sampled.
// Codes outside the defined set behave as register direct.
module ea_addr_gen
    import ea_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     reg_a,
    input  logic [AW-1:0]     reg_b,
    input  logic [AW-1:0]     imm,
    input  logic [SZW-1:0]    size_log2,
    output logic [AW-1:0]     ea,
    output logic [AW-1:0]     direct_val,
    output logic [AW-1:0]     wb_val,
    output ea_class_t         cls
);

    logic [AW-1:0] step;
    logic [AW-1:0] idx_scaled;

    // Access size and scaled index: scaling is a left shift by the exponent.
    always_comb begin
        step       = AW'(1) << size_log2;
        idx_scaled = reg_b << size_log2;
    end

    // Mode decode: address, direct value, write-back value and class.
    always_comb begin
        cls        = '0;
        ea         = '0;
        direct_val = reg_a;
        wb_val     = reg_a;
        case (mode)
            EM_IMM: direct_val = imm;
            EM_RIND: begin
                ea            = reg_a;
                cls.needs_mem = 1'b1;
            end
            EM_DISP: begin
                ea            = reg_a + imm;
                cls.needs_mem = 1'b1;
            end
            EM_IDX: begin
                ea            = reg_a + reg_b;
                cls.needs_mem = 1'b1;
            end
            EM_ABS: begin
                ea            = imm;
                cls.needs_mem = 1'b1;
            end
            EM_MIND: begin
                ea            = reg_a;
                cls.needs_mem = 1'b1;
                cls.two_level = 1'b1;
            end
            EM_POSTINC: begin
                ea              = reg_a;
                wb_val          = reg_a + step;
                cls.needs_mem   = 1'b1;
                cls.writes_base = 1'b1;
            end
            EM_POSTDEC: begin
                ea              = reg_a;
                wb_val          = reg_a - step;
                cls.needs_mem   = 1'b1;
                cls.writes_base = 1'b1;
            end
            EM_SCALED: begin
                ea            = imm + reg_a + idx_scaled;
                cls.needs_mem = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/ea_seq.sv
// Module: ea_seq
// Purpose: sequences the reads for one descriptor and registers every output.
// Assumes: a read response arrives no earlier than the cycle after mem_req.
// Only one read is outstanding at a time.
// start is ignored unless the sequencer is idle.
module ea_seq
    import ea_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  ea_class_t     cls,
    input  logic [AW-1:0] ea,
    input  logic [AW-1:0] reg_a,
    input  logic [AW-1:0] direct_val,
    input  logic [AW-1:0] wb_val,
    input  logic          mem_rvalid,
    input  logic [AW-1:0] mem_rdata,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          done,
    output logic [AW-1:0] operand,
    output logic [AW-1:0] addr,
    output logic          wb_en,
    output logic [AW-1:0] wb_data
);

    typedef enum logic [1:0] {S_IDLE, S_PTR, S_DATA} seq_state_e;

    seq_state_e    state;
    logic [AW-1:0] ea_q;
    logic [AW-1:0] wb_q;
    logic          wbm_q;

    // Sequencer: accept, issue reads, complete with one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ea_q     <= '0;
            wb_q     <= '0;
            wbm_q    <= 1'b0;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            done     <= 1'b0;
            operand  <= '0;
            addr     <= '0;
            wb_en    <= 1'b0;
            wb_data  <= '0;
        end else begin
            mem_req <= 1'b0;
            done    <= 1'b0;
            wb_en   <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        if (!cls.needs_mem) begin
                            done    <= 1'b1;
                            operand <= direct_val;
                            addr    <= '0;
                        end else begin
                            mem_req  <= 1'b1;
                            mem_addr <= cls.two_level ? reg_a : ea;
                            ea_q     <= ea;
                            wb_q     <= wb_val;
                            wbm_q    <= cls.writes_base;
                            state    <= cls.two_level ? S_PTR : S_DATA;
                        end
                    end
                end
                S_PTR: begin
                    if (mem_rvalid) begin
                        mem_req  <= 1'b1;
                        mem_addr <= mem_rdata;
                        ea_q     <= mem_rdata;
                        state    <= S_DATA;
                    end
                end
                S_DATA: begin
                    if (mem_rvalid) begin
                        done    <= 1'b1;
                        operand <= mem_rdata;
                        addr    <= ea_q;
                        wb_en   <= wbm_q;
                        if (wbm_q) wb_data <= wb_q;
                        state   <= S_IDLE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Reset clears all strobes.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!done && !mem_req && !wb_en));

    // Read data lands on operand in the cycle after the final response.
    assert_rdata_to_operand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_DATA && mem_rvalid) |=> (done && operand == $past(mem_rdata)));

    // Pointer response becomes the next request address.
    assert_pointer_chain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PTR && mem_rvalid) |=> (mem_req && mem_addr == $past(mem_rdata)));

    // Write-back only accompanies completion.
    assert_wb_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> done);

    // A pending read blocks any new start.
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE && !mem_rvalid) |=> (!done && !mem_req));

    // Request strobes never come back to back.
    assert_req_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

endmodule

// File: rtl/ea_unit.sv
// Module: ea_unit (top)
// Purpose: resolves an operand descriptor to an address and an operand value.
// Covers post-modify write-back and a two-level indirect read.
// Assumes: decode supplies the register values, and the register file
// consumes the wb_en/wb_data strobe.
module ea_unit
    import ea_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [AW-1:0]     reg_a,
    input  logic [AW-1:0]     reg_b,
    input  logic [AW-1:0]     imm,
    input  logic [SZW-1:0]    size_log2,
    input  logic              mem_rvalid,
    input  logic [AW-1:0]     mem_rdata,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    output logic              done,
    output logic [AW-1:0]     operand,
    output logic [AW-1:0]     addr,
    output logic              wb_en,
    output logic [AW-1:0]     wb_data
);

    ea_class_t     cls;
    logic [AW-1:0] ea;
    logic [AW-1:0] direct_val;
    logic [AW-1:0] wb_val;

    ea_addr_gen #(.AW(AW), .SZW(SZW)) u_gen (
        .mode       (mode),
        .reg_a      (reg_a),
        .reg_b      (reg_b),
        .imm        (imm),
        .size_log2  (size_log2),
        .ea         (ea),
        .direct_val (direct_val),
        .wb_val     (wb_val),
        .cls        (cls)
    );

    ea_seq #(.AW(AW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .cls        (cls),
        .ea         (ea),
        .reg_a      (reg_a),
        .direct_val (direct_val),
        .wb_val     (wb_val),
        .mem_rvalid (mem_rvalid),
        .mem_rdata  (mem_rdata),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .done       (done),
        .operand    (operand),
        .addr       (addr),
        .wb_en      (wb_en),
        .wb_data    (wb_data)
    );

endmodule

// File: tb/ea_unit_tb.sv
// Bench: behavioural reference model updated at each rising edge.
// Outputs are compared at every falling edge. The memory responder and the
// stimulus drive inputs at falling edges.
module ea_unit_tb;

    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [3:0]    mode = '0;
    logic [AW-1:0] reg_a = '0, reg_b = '0, imm = '0;
    logic [1:0]    size_log2 = '0;
    logic          mem_rvalid = 1'b0;
    logic [AW-1:0] mem_rdata = '0;
    logic          mem_req, done, wb_en;
    logic [AW-1:0] mem_addr, operand, addr, wb_data;

    always #5 clk = ~clk;

    ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .reg_a(reg_a), .reg_b(reg_b), .imm(imm), .size_log2(size_log2),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .done(done),
        .operand(operand), .addr(addr), .wb_en(wb_en), .wb_data(wb_data)
    );

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    int    lat = 1;
    string cur_tag = "R1";

    // Memory contents are a fixed function of the address.
    function automatic logic [AW-1:0] memf(input logic [AW-1:0] a);
        return {a[15:0], a[31:16]} ^ 32'h5A5A_1234;
    endfunction

    // Reference model state
    bit            m_busy = 0, m_done = 0, m_req = 0, m_wb = 0, m_wbm = 0;
    int            m_left = 0;
    logic [AW-1:0] m_op = '0, m_addr = '0, m_req_addr = '0, m_fin = '0;
    logic [AW-1:0] m_wbv = '0, m_wbd = '0;

    // Model update at each rising edge.
    always @(posedge clk) begin
        logic [AW-1:0] stepv, eav;
        m_done = 0; m_req = 0; m_wb = 0;
        stepv = 32'd1 << size_log2;
        if (!rst_n) begin
            m_busy = 0; m_left = 0;
        end else if (!m_busy) begin
            if (start) begin
                eav = reg_a;
                case (mode)
                    4'd3: eav = reg_a + imm;
                    4'd4: eav = reg_a + reg_b;
                    4'd5: eav = imm;
                    4'd9: eav = imm + reg_a + (reg_b << size_log2);
                    default: eav = reg_a;
                endcase
                if (mode == 4'd1) begin
                    m_done = 1; m_op = imm; m_addr = '0;
                end else if (mode == 4'd0 || mode > 4'd9) begin
                    m_done = 1; m_op = reg_a; m_addr = '0;
                end else begin
                    m_busy = 1;
                    m_left = (mode == 4'd6) ? 2 : 1;
                    m_req = 1;
                    m_req_addr = eav;
                    m_fin = eav;
                    m_wbm = (mode == 4'd7) || (mode == 4'd8);
                    m_wbv = (mode == 4'd7) ? reg_a + stepv : reg_a - stepv;
                end
            end
        end else if (mem_rvalid) begin
            m_left = m_left - 1;
            if (m_left > 0) begin
                m_req = 1; m_req_addr = mem_rdata; m_fin = mem_rdata;
            end else begin
                m_done = 1; m_op = mem_rdata; m_addr = m_fin;
                m_wb = m_wbm; m_wbd = m_wbv; m_busy = 0;
            end
        end
    end

    task automatic chk(input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", cur_tag, what, act, exp);
        end
    endtask

    // Per-cycle compare, memory responder and watchdog.
    bit            pend = 0;
    int            pend_cnt = 0;
    logic [AW-1:0] pend_addr = '0;
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
        chk("done", {31'd0, done}, {31'd0, m_done});
        chk("mem_req", {31'd0, mem_req}, {31'd0, m_req});
        chk("wb_en", {31'd0, wb_en}, {31'd0, m_wb});
        if (m_done) begin
            chk("operand", operand, m_op);
            chk("addr", addr, m_addr);
        end
        if (m_req) chk("mem_addr", mem_addr, m_req_addr);
        if (m_wb) chk("wb_data", wb_data, m_wbd);
        // responder: at least one cycle after the request
        mem_rvalid <= 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                mem_rvalid <= 1'b1;
                mem_rdata <= memf(pend_addr);
                pend = 0;
            end else pend_cnt--;
        end
        if (mem_req) begin
            pend = 1; pend_addr = mem_addr; pend_cnt = lat;
        end
    end

    // Issue one descriptor, optionally poking start while busy, and wait for done.
    task automatic run_op(input string tag, input logic [3:0] md, input logic [AW-1:0] a,
                          input logic [AW-1:0] b, input logic [AW-1:0] im,
                          input logic [1:0] sz, input int latency, input bit poke);
        cur_tag = tag;
        lat = latency;
        mode = md; reg_a = a; reg_b = b; imm = im; size_log2 = sz;
        start = 1'b1;
        @(negedge clk);
        if (poke) begin
            mode = 4'd1; imm = 32'hDEAD_0000;
            @(negedge clk);
            start = 1'b0;
        end else start = 1'b0;
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);   // R1: reset-state checks run every cycle
        rst_n = 1'b1;
        @(negedge clk);
        run_op("R2", 4'd0, 32'h1111_2222, 32'h0, 32'h0, 2'd0, 1, 0);
        run_op("R2", 4'd12, 32'hCAFE_0001, 32'h5, 32'h7, 2'd1, 1, 0);
        run_op("R3", 4'd1, 32'h1, 32'h2, 32'h8765_4321, 2'd0, 1, 0);
        run_op("R4", 4'd2, 32'h0000_1000, 32'h0, 32'h0, 2'd2, 0, 0);
        run_op("R4", 4'd3, 32'hFFFF_FFF0, 32'h0, 32'h0000_0020, 2'd2, 2, 0);
        run_op("R4", 4'd4, 32'h0000_4000, 32'h0000_0123, 32'h0, 2'd0, 1, 0);
        run_op("R4", 4'd5, 32'h9999_9999, 32'h0, 32'h0000_0ABC, 2'd0, 0, 0);
        for (int s = 0; s < 4; s++)
            run_op("R5", 4'd9, 32'h0000_2000, 32'h0000_0011, 32'h0000_0100, 2'(s), 1, 0);
        run_op("R6", 4'd3, 32'h0000_0040, 32'h0, 32'h0000_0004, 2'd2, 4, 0);
        run_op("R7", 4'd6, 32'h0000_3000, 32'h0, 32'h0, 2'd2, 0, 0);
        run_op("R7", 4'd6, 32'h1234_0000, 32'h0, 32'h0, 2'd3, 3, 0);
        run_op("R8", 4'd7, 32'h0000_5000, 32'h0, 32'h0, 2'd2, 1, 0);
        run_op("R8", 4'd8, 32'h0000_0004, 32'h0, 32'h0, 2'd3, 2, 0);
        run_op("R8", 4'd7, 32'hFFFF_FFFF, 32'h0, 32'h0, 2'd0, 0, 0);
        run_op("R9", 4'd2, 32'h0000_7000, 32'h0, 32'h0, 2'd0, 3, 1);
        run_op("R9", 4'd6, 32'h0000_7700, 32'h0, 32'h0, 2'd0, 2, 1);
        // R10: descriptors chained into the done cycle of the previous one
        run_op("R10", 4'd8, 32'h0000_0100, 32'h0, 32'h0, 2'd1, 0, 0);
        run_op("R10", 4'd0, 32'h0000_0ABC, 32'h0, 32'h0, 2'd0, 0, 0);
        run_op("R10", 4'd1, 32'h0, 32'h0, 32'h0000_0055, 2'd0, 0, 0);
        run_op("R10", 4'd6, 32'h0000_0200, 32'h0, 32'h0, 2'd0, 0, 0);
        run_op("R10", 4'd7, 32'h0000_0300, 32'h0, 32'h0, 2'd3, 1, 0);
        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule